// File: doc/BRIEF.md
# Dual-Channel Potentiometer Wiper and Control Register Bank

This block holds the digital state behind a pair of digitally controlled potentiometer channels. Each channel keeps a live wiper register, whose value picks one of 64 taps on a resistor ladder, and a live 3-bit comparator control register. Each channel also has four stored slots. Every slot holds a wiper value and a control value together. The live registers drive the tap select and the comparator control outputs. A host reaches the block through a single-cycle command port. Through that port it can read or write the live registers, copy the live pair into a slot, copy a slot back into the live registers, and read or write a slot directly.

The stored slots model nonvolatile cells. They are cleared to parameter defaults only by their own reset, `nv_rst_n`. The system reset `rst_n` stands for a power cycle: it clears the live registers, and one cycle after release it reloads both live registers of every channel from slot 0. Any write into a slot starts a fixed busy window, and the block refuses every command while that window is open. When the active-low protect input is held low, slot writes are refused, a sticky error flag is raised, and live writes still go through. Each channel also carries a registered comparator output stage. The control bits of that channel select enable, hold or forced-low behaviour for it.

Top module: `wrb_bank`

## Requirements
- R1: While `rst_n` is low, each channel reports tap 0 and control 0, `busy` is high, and `wp_err` is low. On the first clock edge after `rst_n` rises, the wiper and the control register of every channel are both loaded from that channel's slot 0. `nv_rst_n` fills every slot with wiper `NV_INIT_WIPER` and control `NV_INIT_ACR`.
- R2: An accepted command with `cmd_op`=1 (live write) loads `cmd_wdata[5:0]` into the wiper and `cmd_wdata[8:6]` into the control register of channel `cmd_ch`, visible after that edge. The other channel is left unchanged.
- R3: An accepted `cmd_op`=0 (live read) raises `rd_valid` for one cycle after the edge. In that cycle `rd_data` = {control, wiper} of channel `cmd_ch`.
- R4: An accepted `cmd_op`=2 (save) copies the live pair of `cmd_ch` into slot `cmd_slot`. An accepted `cmd_op`=4 (slot read) returns that slot as {control, wiper} on `rd_data`, with `rd_valid` timed as in R3.
- R5: An accepted `cmd_op`=3 (restore) loads the live wiper and control of `cmd_ch` from slot `cmd_slot`.
- R6: An accepted `cmd_op`=5 (slot write) stores `cmd_wdata` into slot `cmd_slot` of `cmd_ch`.
- R7: An accepted save or slot write holds `busy` high for exactly `NV_WRITE_CYCLES` cycles after its edge. A command presented while `busy` is high has no effect on any register.
- R8: When `wp_n` is low, a save or slot write leaves every slot unchanged, does not raise `busy`, and sets `wp_err`. `wp_err` then stays high until `rst_n`. Live writes still take effect.
- R9: Control bit 2 (shutdown) drives the channel's `cmp_out` low. Otherwise, with bit 1 (latch) set, `cmp_out` keeps its value. Otherwise `cmp_out` follows `cmp_raw` when bit 0 (enable) is set and is low when it is clear. The output is registered, one edge after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset of the live logic |
| nv_rst_n | input | 1 | Active-low asynchronous initialisation of the stored slots |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code (0 live read, 1 live write, 2 save, 3 restore, 4 slot read, 5 slot write) |
| cmd_ch | input | 1 | Channel index |
| cmd_slot | input | 2 | Stored slot index |
| cmd_wdata | input | 9 | Write data, {control[2:0], wiper[5:0]} |
| wp_n | input | 1 | Active-low write protect for slot writes |
| cmp_raw | input | 2 | Raw comparator decision per channel |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 9 | Read data, {control, wiper} |
| busy | output | 1 | Recall or slot write in progress; commands are refused |
| wp_err | output | 1 | Sticky flag for refused protected writes |
| tap_sel | output | 12 | Wiper tap select, channel n in bits [6n+5:6n] |
| acr_out | output | 6 | Control register, channel n in bits [3n+2:3n] |
| cmp_out | output | 2 | Conditioned comparator output per channel |

## Verification
The power-up recall is the hardest behaviour to reach from the ports. It needs slot 0 to hold values that differ from the initialisation defaults, and it needs a live reset that leaves the slots alone. The stimulus first writes distinct patterns into slot 0 of both channels. It waits out each busy window, pulses only `rst_n`, and then checks tap and control on the first cycle after release. Busy rejection is reached in a similar way. A live write is issued inside a slot-write window, and the bench then reads back to confirm that nothing moved.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   localparam int ACR_W = 3;
   localparam int ACR_EN = 0;
   localparam int ACR_LATCH = 1;
   localparam int ACR_SHDN = 2;

   typedef enum logic [2:0] {
      OP_RD_LIVE = 3'd0,
      OP_WR_LIVE = 3'd1,
      OP_SAVE    = 3'd2,
      OP_RESTORE = 3'd3,
      OP_RD_SLOT = 3'd4,
      OP_WR_SLOT = 3'd5
   } wrb_op_e;
endpackage

// File: rtl/wrb_nv_timer.sv
module wrb_nv_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/wrb_cmp_ctl.sv
module wrb_cmp_ctl
   import wrb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [ACR_W-1:0] acr,
   output logic             out
);
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= 1'b0;
      else if (acr[ACR_SHDN])
         out_q <= 1'b0;
      else if (!acr[ACR_LATCH])
         out_q <= acr[ACR_EN] & raw;
   end

   assign out = out_q;
endmodule

// File: rtl/wrb_channel.sv
module wrb_channel #(
   parameter int WIPER_W = 6,
   parameter int SLOTS = 4,
   parameter int INIT_WIPER = 32,
   parameter int INIT_ACR = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 nv_rst_n,
   input  logic                                 recall,
   input  logic                                 wr_live,
   input  logic                                 save,
   input  logic                                 restore,
   input  logic                                 wr_slot,
   input  logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] slot_idx,
   input  logic [WIPER_W+wrb_pkg::ACR_W-1:0]    wdata,
   output logic [WIPER_W+wrb_pkg::ACR_W-1:0]    live_word,
   output logic [WIPER_W+wrb_pkg::ACR_W-1:0]    slot_word
);
   localparam int DW = WIPER_W + wrb_pkg::ACR_W;
   localparam logic [DW-1:0] INIT_WORD =
      {wrb_pkg::ACR_W'(INIT_ACR), WIPER_W'(INIT_WIPER)};

   logic [DW-1:0] live_q;
   logic [DW-1:0] store_q [SLOTS];
   logic          idx_ok;

   assign idx_ok = (int'(slot_idx) < SLOTS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live_q <= '0;
      else if (recall)
         live_q <= store_q[0];
      else if (wr_live)
         live_q <= wdata;
      else if (restore && idx_ok)
         live_q <= store_q[slot_idx];
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge nv_rst_n) begin
         if (!nv_rst_n)
            store_q[s] <= INIT_WORD;
         else if (int'(slot_idx) == s) begin
            if (wr_slot)
               store_q[s] <= wdata;
            else if (save)
               store_q[s] <= live_q;
         end
      end
   end

   assign live_word = live_q;
   assign slot_word = idx_ok ? store_q[slot_idx] : '0;
endmodule

// File: rtl/wrb_bank.sv
module wrb_bank
   import wrb_pkg::*;
#(
   parameter int CHANNELS = 2,
   parameter int WIPER_W = 6,
   parameter int SLOTS = 4,
   parameter int NV_WRITE_CYCLES = 8,
   parameter int NV_INIT_WIPER = 32,
   parameter int NV_INIT_ACR = 0,
   localparam int DW = WIPER_W + ACR_W,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          nv_rst_n,
   input  logic                          cmd_valid,
   input  logic [2:0]                    cmd_op,
   input  logic [CH_W-1:0]               cmd_ch,
   input  logic [SLOT_W-1:0]             cmd_slot,
   input  logic [DW-1:0]                 cmd_wdata,
   input  logic                          wp_n,
   input  logic [CHANNELS-1:0]           cmp_raw,
   output logic                          rd_valid,
   output logic [DW-1:0]                 rd_data,
   output logic                          busy,
   output logic                          wp_err,
   output logic [CHANNELS*WIPER_W-1:0]   tap_sel,
   output logic [CHANNELS*ACR_W-1:0]     acr_out,
   output logic [CHANNELS-1:0]           cmp_out
);
   if (CHANNELS < 1) begin : g_bad_ch
      $error("wrb_bank: CHANNELS must be at least 1");
   end
   if (WIPER_W < 1) begin : g_bad_w
      $error("wrb_bank: WIPER_W must be at least 1");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("wrb_bank: SLOTS must be at least 1");
   end
   if (NV_WRITE_CYCLES < 1) begin : g_bad_nv
      $error("wrb_bank: NV_WRITE_CYCLES must be at least 1");
   end

   logic          recall_q;
   logic          timer_busy;
   logic          accept;
   logic          nv_op;
   logic          nv_go;
   logic          wp_refuse;
   logic          ch_ok;
   logic          rd_valid_q;
   logic [DW-1:0] rd_data_q;
   logic          wp_err_q;
   logic [DW-1:0] live_word [CHANNELS];
   logic [DW-1:0] slot_word [CHANNELS];
   wrb_op_e       op;

   assign op        = wrb_op_e'(cmd_op);
   assign busy      = recall_q | timer_busy;
   assign accept    = cmd_valid & ~busy;
   assign nv_op     = (op == OP_SAVE) || (op == OP_WR_SLOT);
   assign nv_go     = accept & nv_op & wp_n;
   assign wp_refuse = accept & nv_op & ~wp_n;
   assign ch_ok     = (int'(cmd_ch) < CHANNELS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         recall_q <= 1'b1;
      else
         recall_q <= 1'b0;
   end

   wrb_nv_timer #(.CYCLES(NV_WRITE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (nv_go),
      .active (timer_busy)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      logic hit;
      assign hit = accept && (int'(cmd_ch) == c);

      wrb_channel #(
         .WIPER_W    (WIPER_W),
         .SLOTS      (SLOTS),
         .INIT_WIPER (NV_INIT_WIPER),
         .INIT_ACR   (NV_INIT_ACR)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .nv_rst_n  (nv_rst_n),
         .recall    (recall_q),
         .wr_live   (hit && (op == OP_WR_LIVE)),
         .save      (hit && wp_n && (op == OP_SAVE)),
         .restore   (hit && (op == OP_RESTORE)),
         .wr_slot   (hit && wp_n && (op == OP_WR_SLOT)),
         .slot_idx  (cmd_slot),
         .wdata     (cmd_wdata),
         .live_word (live_word[c]),
         .slot_word (slot_word[c])
      );

      wrb_cmp_ctl u_cmp (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (cmp_raw[c]),
         .acr   (live_word[c][DW-1:WIPER_W]),
         .out   (cmp_out[c])
      );

      assign tap_sel[c*WIPER_W +: WIPER_W] = live_word[c][WIPER_W-1:0];
      assign acr_out[c*ACR_W +: ACR_W]     = live_word[c][DW-1:WIPER_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         wp_err_q   <= 1'b0;
      end else begin
         rd_valid_q <= accept && ((op == OP_RD_LIVE) || (op == OP_RD_SLOT));
         if (accept && ch_ok && (op == OP_RD_LIVE))
            rd_data_q <= live_word[cmd_ch];
         else if (accept && ch_ok && (op == OP_RD_SLOT))
            rd_data_q <= slot_word[cmd_ch];
         if (wp_refuse)
            wp_err_q <= 1'b1;
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;
   assign wp_err   = wp_err_q;
endmodule

// File: rtl/wrb_bank_chk.sv
module wrb_bank_chk
   import wrb_pkg::*;
#(
   parameter int CHANNELS = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cmd_valid,
   input logic [2:0]                cmd_op,
   input logic                      wp_n,
   input logic                      busy,
   input logic                      wp_err,
   input logic                      rd_valid,
   input logic [CHANNELS*ACR_W-1:0] acr_out,
   input logic [CHANNELS-1:0]       cmp_out
);
   logic nv_cmd;
   assign nv_cmd = cmd_valid && !busy &&
                   ((cmd_op == OP_SAVE) || (cmd_op == OP_WR_SLOT));

   p_nv_starts_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_cmd && wp_n) |=> busy);

   p_wp_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_cmd && !wp_n) |=> (wp_err && !busy));

   p_wp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wp_err |=> wp_err);

   p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && ((cmd_op == OP_RD_LIVE) || (cmd_op == OP_RD_SLOT)))
      |=> rd_valid);

   for (genvar c = 0; c < CHANNELS; c++) begin : g_c
      p_shutdown_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
         acr_out[c*ACR_W + ACR_SHDN] |=> !cmp_out[c]);
   end
endmodule

bind wrb_bank wrb_bank_chk #(.CHANNELS(CHANNELS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .wp_n      (wp_n),
   .busy      (busy),
   .wp_err    (wp_err),
   .rd_valid  (rd_valid),
   .acr_out   (acr_out),
   .cmp_out   (cmp_out)
);

// File: tb/wrb_bank_tb.sv
`timescale 1ns/100ps
module wrb_bank_tb;
   localparam int NVC = 4;
   localparam int INIT_W = 32;
   localparam int INIT_A = 0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nv_rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic       cmd_ch = 1'b0;
   logic [1:0] cmd_slot = '0;
   logic [8:0] cmd_wdata = '0;
   logic       wp_n = 1'b1;
   logic [1:0] cmp_raw = '0;
   logic       rd_valid;
   logic [8:0] rd_data;
   logic       busy;
   logic       wp_err;
   logic [11:0] tap_sel;
   logic [5:0] acr_out;
   logic [1:0] cmp_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   wrb_bank #(.NV_WRITE_CYCLES(NVC), .NV_INIT_WIPER(INIT_W), .NV_INIT_ACR(INIT_A)) u_dut (
      .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_slot(cmd_slot), .cmd_wdata(cmd_wdata),
      .wp_n(wp_n), .cmp_raw(cmp_raw), .rd_valid(rd_valid), .rd_data(rd_data),
      .busy(busy), .wp_err(wp_err), .tap_sel(tap_sel), .acr_out(acr_out),
      .cmp_out(cmp_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmd(input int op, input int ch, input int slot, input int data);
      cmd_valid = 1'b1;
      cmd_op    = 3'(op);
      cmd_ch    = 1'(ch);
      cmd_slot  = 2'(slot);
      cmd_wdata = 9'(data);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   function automatic int tap(input int ch);
      return int'(tap_sel[ch*6 +: 6]);
   endfunction

   function automatic int acr(input int ch);
      return int'(acr_out[ch*3 +: 3]);
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int pat;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 tap0 in reset", tap(0), 0);
      check("R1 acr1 in reset", acr(1), 0);
      check("R1 busy in reset", int'(busy), 1);
      check("R1 wp_err in reset", int'(wp_err), 0);
      nv_rst_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 recall tap0", tap(0), INIT_W);
      check("R1 recall tap1", tap(1), INIT_W);
      check("R1 recall acr0", acr(0), INIT_A);
      check("R1 busy cleared", int'(busy), 0);

      // R2/R3: sweep all wipers on both channels
      for (int ch = 0; ch < 2; ch++) begin
         for (int w = 0; w < 64; w++) begin
            pat = (((w * 5 + ch) % 4) << 6) | w;   // control bit 2 kept low here
            cmd(1, ch, 0, pat);
            check("R2 live tap", tap(ch), w);
            check("R2 live acr", acr(ch), (w * 5 + ch) % 4);
            cmd(0, ch, 0, 0);
            check("R3 rd_valid", int'(rd_valid), 1);
            check("R3 rd_data", int'(rd_data), pat);
         end
      end
      cmd(1, 0, 0, 9'h015);
      check("R2 other channel untouched", tap(1), 63);
      @(negedge clk);
      check("R3 rd_valid one cycle", int'(rd_valid), 0);

      // R6/R4/R7: slot write sweep with busy length
      for (int ch = 0; ch < 2; ch++) begin
         for (int s = 0; s < 4; s++) begin
            pat = ((s * 3 + ch) % 8 << 6) | (s * 17 + ch * 7);
            cmd(5, ch, s, pat);
            n = 0;
            while (busy) begin n++; @(negedge clk); end
            check("R7 busy length", n, NVC);
            cmd(4, ch, s, 0);
            check("R6 slot readback", int'(rd_data), pat);
         end
      end

      // R7: command during busy has no effect
      cmd(1, 1, 0, 9'h02A);
      cmd(5, 1, 3, 9'h111);
      cmd(1, 1, 0, 9'h005);
      check("R7 busy still high", int'(busy), 1);
      wait_idle();
      check("R7 ignored live write", tap(1), 9'h02A & 63);

      // R4: save, R5: restore
      cmd(1, 0, 0, 9'h0C9);
      cmd(2, 0, 2, 0);
      wait_idle();
      cmd(4, 0, 2, 0);
      check("R4 save readback", int'(rd_data), 9'h0C9);
      cmd(1, 0, 0, 9'h003);
      cmd(3, 0, 2, 0);
      check("R5 restore tap", tap(0), 9'h0C9 & 63);
      check("R5 restore acr", acr(0), 9'h0C9 >> 6);

      // R8: write protect
      wp_n = 1'b0;
      cmd(5, 0, 1, 9'h1FF);
      check("R8 no busy", int'(busy), 0);
      check("R8 wp_err set", int'(wp_err), 1);
      cmd(2, 1, 1, 0);
      cmd(4, 0, 1, 0);
      check("R8 slot unchanged ch0", int'(rd_data), ((3 % 8) << 6) | 17);
      cmd(4, 1, 1, 0);
      check("R8 save refused ch1", int'(rd_data), ((4 % 8) << 6) | 24);
      cmd(1, 1, 0, 9'h033);
      check("R8 live write allowed", tap(1), 9'h033);
      wp_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 wp_err sticky", int'(wp_err), 1);

      // R9: comparator conditioning on channel 0
      cmp_raw = 2'b01;
      cmd(1, 0, 0, 9'h040);      // enable
      @(negedge clk);
      check("R9 follow high", int'(cmp_out[0]), 1);
      cmp_raw = 2'b00;
      @(negedge clk);
      check("R9 follow low", int'(cmp_out[0]), 0);
      cmp_raw = 2'b01;
      @(negedge clk);
      cmd(1, 0, 0, 9'h0C0);      // enable + latch
      cmp_raw = 2'b00;
      repeat (3) @(negedge clk);
      check("R9 latched hold", int'(cmp_out[0]), 1);
      cmd(1, 0, 0, 9'h040);      // latch cleared
      @(negedge clk);
      check("R9 latch released", int'(cmp_out[0]), 0);
      cmp_raw = 2'b01;
      cmd(1, 0, 0, 9'h140);      // enable + shutdown
      @(negedge clk);
      check("R9 shutdown low", int'(cmp_out[0]), 0);
      cmd(1, 0, 0, 9'h000);
      @(negedge clk);
      check("R9 disabled low", int'(cmp_out[0]), 0);

      // R1: power-up recall from slot 0 without storage init
      cmd(5, 0, 0, 9'h0A5);
      wait_idle();
      cmd(5, 1, 0, 9'h19C);
      wait_idle();
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 wp_err cleared by reset", int'(wp_err), 0);
      check("R1 tap reset", tap(0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 recall ch0 tap", tap(0), 9'h0A5 & 63);
      check("R1 recall ch0 acr", acr(0), 9'h0A5 >> 6);
      check("R1 recall ch1 tap", tap(1), 9'h19C & 63);
      check("R1 recall ch1 acr", acr(1), 9'h19C >> 6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule